// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block records insertion and removal events for up to 32 bus slots and presents them to software through a small register window that is addressed by byte offset. Each insert or remove event clears both event masks and then sets the bit for the slot concerned in one of them. The event also sets a sticky bit in a general-purpose event status byte, which a neighbouring event block samples and clears. A slot that is already present at boot produces no event.

Software requests a device eject by writing a slot bitmap. The lowest set bit selects the slot. The request goes out as a one-cycle pulse that carries the slot index, but only when that slot is hotplug-capable. A read-only register reports which slots may be removed. It is rebuilt from the static capability input after every reset.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: During reset and afterwards until the first event or write, the inserted mask (offset 0), the removed mask (offset 4), `evt_sts_o` and `ej_vld_o` are all zero. From the second rising edge after reset is released, offset 12 reads `hp_cap_i`.
- R2: A write to offset 0 replaces the inserted mask with `reg_wdata_i`. A write to offset 4 replaces the removed mask. A read of either offset returns the stored value in the same cycle.
- R3: An insert event (`slot_ev_i` = 2'b10) clears both masks. On the next edge the inserted mask holds only bit `slot_idx_i` and the removed mask is zero.
- R4: A remove event (`slot_ev_i` = 2'b11) clears both masks. On the next edge the removed mask holds only bit `slot_idx_i` and the inserted mask is zero.
- R5: Every insert or remove event sets bit 1 of `evt_sts_o`. That bit stays set until a cycle in which `sts_clr_i[1]` is high and no event occurs. Bits 0 and 7:2 of `evt_sts_o` are always zero.
- R6: A boot-present event (`slot_ev_i` = 2'b01) or no event (2'b00) leaves both masks and `evt_sts_o` unchanged.
- R7: A nonzero write to offset 8 selects the lowest set bit of the written value. If that slot is removable, `ej_vld_o` is high for exactly the cycle after the write, and `ej_slot_o` gives the slot index during that cycle.
- R8: No eject pulse is produced when the selected slot's bit in the removable mask is 0, or when the written value is zero.
- R9: Offset 8 always reads zero. Offset 12 returns the removable mask, and writes to offset 12 have no effect.
- R10: Any offset other than 0, 4, 8 and 12 reads as zero, and a write to it changes no register.
- R11: When an insert or remove event and a software write to offset 0 or 4 fall in the same cycle, the event's result is stored and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| slot_ev_i | input | 2 | Slot event code: 00 none, 01 boot-present, 10 insert, 11 remove |
| slot_idx_i | input | 5 | Slot number of the event |
| hp_cap_i | input | 32 | Static mask of hotplug-capable slots |
| sts_clr_i | input | 8 | Write-one-to-clear strobe for the status byte |
| evt_sts_o | output | 8 | General-purpose event status byte; bit 1 signals hotplug |
| ej_vld_o | output | 1 | One-cycle eject request |
| ej_slot_o | output | 5 | Slot index of the eject request |

## Verification
The bound checker verifies the following on every cycle:
- Each insert or remove leaves one slot bit set in the correct mask and clears the other mask.
- The status bit is set after each such event, and its unused bits stay zero.
- A boot-present event changes no state.
- Every eject pulse follows a nonzero eject write and names a removable slot.
- Offset 8 reads zero.

Only the directed scenarios can show the rest: the exact read-back of software-written masks, the lowest-set-bit choice for multi-bit eject values, suppression for non-capable slots, offsets that ignore writes, and the precedence of an event over a same-cycle mask write.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  typedef enum logic [1:0] {
    HP_EV_NONE   = 2'b00,
    HP_EV_COLD   = 2'b01,
    HP_EV_INSERT = 2'b10,
    HP_EV_REMOVE = 2'b11
  } hp_ev_e;

  localparam int unsigned OFS_INS = 0;
  localparam int unsigned OFS_REM = 4;
  localparam int unsigned OFS_EJ  = 8;
  localparam int unsigned OFS_RMV = 12;
  localparam int unsigned STS_W   = 8;
  localparam int unsigned STS_HP  = 1;
endpackage

// File: rtl/slot_hp_lsb.sv
module slot_hp_lsb #(
  parameter int unsigned N      = 32,
  parameter int unsigned SLOT_W = $clog2(N)
) (
  input  logic [N-1:0]      vec_i,
  output logic              found_o,
  output logic [SLOT_W-1:0] idx_o
);
  // scan from the top so the lowest set bit is the last one assigned
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = SLOT_W'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/slot_hp_evt.sv
module slot_hp_evt
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hp_ev_e            ev_i,
  input  logic [SLOT_W-1:0] idx_i,
  input  logic              wr_ins_i,
  input  logic              wr_rem_i,
  input  logic [NSLOT-1:0]  wdata_i,
  input  logic [STS_W-1:0]  sts_clr_i,
  output logic [NSLOT-1:0]  ins_o,
  output logic [NSLOT-1:0]  rem_o,
  output logic [STS_W-1:0]  sts_o
);
  logic             hot_ev;
  logic [NSLOT-1:0] slot_bit;
  logic             sts_hp_q;

  assign hot_ev   = (ev_i == HP_EV_INSERT) || (ev_i == HP_EV_REMOVE);
  assign slot_bit = NSLOT'(1) << idx_i;

  // event takes precedence over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_o <= '0;
      rem_o <= '0;
    end else if (hot_ev) begin
      ins_o <= (ev_i == HP_EV_INSERT) ? slot_bit : '0;
      rem_o <= (ev_i == HP_EV_REMOVE) ? slot_bit : '0;
    end else begin
      if (wr_ins_i) ins_o <= wdata_i;
      if (wr_rem_i) rem_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sts_hp_q <= 1'b0;
    else if (hot_ev)          sts_hp_q <= 1'b1;
    else if (sts_clr_i[STS_HP]) sts_hp_q <= 1'b0;
  end

  always_comb begin
    sts_o         = '0;
    sts_o[STS_HP] = sts_hp_q;
  end
endmodule

// File: rtl/slot_hp_eject.sv
module slot_hp_eject #(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [NSLOT-1:0]  sel_i,
  input  logic [NSLOT-1:0]  rmv_i,
  output logic              vld_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              found;
  logic [SLOT_W-1:0] idx;

  slot_hp_lsb #(.N(NSLOT), .SLOT_W(SLOT_W)) u_lsb (
    .vec_i  (sel_i),
    .found_o(found),
    .idx_o  (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      slot_o <= '0;
    end else begin
      vld_o <= req_i && found && rmv_i[idx];
      if (req_i) slot_o <= idx;
    end
  end
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [1:0]        slot_ev_i,
  input  logic [SLOT_W-1:0] slot_idx_i,
  input  logic [NSLOT-1:0]  hp_cap_i,
  input  logic [STS_W-1:0]  sts_clr_i,
  output logic [STS_W-1:0]  evt_sts_o,
  output logic              ej_vld_o,
  output logic [SLOT_W-1:0] ej_slot_o
);
  localparam logic [ADDR_W-1:0] A_INS = ADDR_W'(OFS_INS);
  localparam logic [ADDR_W-1:0] A_REM = ADDR_W'(OFS_REM);
  localparam logic [ADDR_W-1:0] A_EJ  = ADDR_W'(OFS_EJ);
  localparam logic [ADDR_W-1:0] A_RMV = ADDR_W'(OFS_RMV);

  logic [NSLOT-1:0] ins_mask, rem_mask, rmv_q;
  logic             load_q;
  logic             wr_ins, wr_rem, wr_ej;

  assign wr_ins = reg_wr_i && (reg_addr_i == A_INS);
  assign wr_rem = reg_wr_i && (reg_addr_i == A_REM);
  assign wr_ej  = reg_wr_i && (reg_addr_i == A_EJ);

  slot_hp_evt #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (hp_ev_e'(slot_ev_i)),
    .idx_i    (slot_idx_i),
    .wr_ins_i (wr_ins),
    .wr_rem_i (wr_rem),
    .wdata_i  (reg_wdata_i[NSLOT-1:0]),
    .sts_clr_i(sts_clr_i),
    .ins_o    (ins_mask),
    .rem_o    (rem_mask),
    .sts_o    (evt_sts_o)
  );

  slot_hp_eject #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_ej (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (wr_ej),
    .sel_i (reg_wdata_i[NSLOT-1:0]),
    .rmv_i (rmv_q),
    .vld_o (ej_vld_o),
    .slot_o(ej_slot_o)
  );

  // removable mask: all ones in reset, narrowed by capability on first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rmv_q  <= '1;
      load_q <= 1'b1;
    end else if (load_q) begin
      rmv_q  <= hp_cap_i;
      load_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_INS:   reg_rdata_o = DATA_W'(ins_mask);
      A_REM:   reg_rdata_o = DATA_W'(rem_mask);
      A_RMV:   reg_rdata_o = DATA_W'(rmv_q);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/slot_hp_chk.sv
module slot_hp_chk
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SLOT_W = $clog2(NSLOT)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [1:0]        slot_ev_i,
  input logic [SLOT_W-1:0] slot_idx_i,
  input logic [STS_W-1:0]  sts_clr_i,
  input logic [STS_W-1:0]  evt_sts_o,
  input logic              ej_vld_o,
  input logic [SLOT_W-1:0] ej_slot_o,
  input logic [NSLOT-1:0]  ins_mask,
  input logic [NSLOT-1:0]  rem_mask,
  input logic [NSLOT-1:0]  rmv_q
);
  p_insert_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_ev_i == HP_EV_INSERT) |=>
      ($onehot(ins_mask) && ins_mask[$past(slot_idx_i)] && rem_mask == '0));

  p_remove_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_ev_i == HP_EV_REMOVE) |=>
      ($onehot(rem_mask) && rem_mask[$past(slot_idx_i)] && ins_mask == '0));

  p_sts_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_ev_i[1]) |=> evt_sts_o[STS_HP]);

  p_sts_unused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(evt_sts_o) <= 1 && (evt_sts_o & ~(STS_W'(1) << STS_HP)) == '0);

  p_cold_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_ev_i[1] && !reg_wr_i && sts_clr_i == '0) |=>
      ($stable(ins_mask) && $stable(rem_mask) && $stable(evt_sts_o)));

  p_ej_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ej_vld_o |-> $past(reg_wr_i && reg_addr_i == ADDR_W'(OFS_EJ) && reg_wdata_i != '0));

  p_ej_removable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ej_vld_o && $stable(rmv_q)) |-> rmv_q[ej_slot_o]);

  p_ej_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(OFS_EJ)) |-> reg_rdata_o == '0);
endmodule

bind slot_hotplug_ctrl slot_hp_chk #(
  .NSLOT(NSLOT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .slot_ev_i  (slot_ev_i),
  .slot_idx_i (slot_idx_i),
  .sts_clr_i  (sts_clr_i),
  .evt_sts_o  (evt_sts_o),
  .ej_vld_o   (ej_vld_o),
  .ej_slot_o  (ej_slot_o),
  .ins_mask   (ins_mask),
  .rem_mask   (rem_mask),
  .rmv_q      (rmv_q)
);

// File: tb/slot_hotplug_ctrl_bench.sv
module slot_hotplug_ctrl_bench;
  localparam logic [31:0] CAP = 32'hFFFF_FFCE; // slots 0, 4, 5 not hotpluggable

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  slot_ev_i = 2'b00;
  logic [4:0]  slot_idx_i = '0;
  logic [31:0] hp_cap_i = CAP;
  logic [7:0]  sts_clr_i = '0;
  logic [7:0]  evt_sts_o;
  logic        ej_vld_o;
  logic [4:0]  ej_slot_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  slot_hotplug_ctrl u_slot_hotplug_ctrl (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic slot_event(logic [1:0] code, logic [4:0] idx);
    @(negedge clk_i);
    slot_ev_i = code; slot_idx_i = idx;
    @(negedge clk_i);
    slot_ev_i = 2'b00;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 ins", u_slot_hotplug_ctrl.reg_rdata_o & 32'h0, 32'h0);
    reg_read(4'd0, d);  check("R1 ins mask", d, 32'h0);
    reg_read(4'd4, d);  check("R1 rem mask", d, 32'h0);
    check("R1 status", {24'h0, evt_sts_o}, 32'h0);
    check("R1 eject", {31'h0, ej_vld_o}, 32'h0);
    reg_read(4'd12, d); check("R1 removable", d, CAP);
  endtask

  task automatic t_sw_rw();
    logic [31:0] d;
    reg_write(4'd0, 32'hA5A5_0F0F);
    reg_write(4'd4, 32'h1234_5678);
    reg_read(4'd0, d); check("R2 ins rw", d, 32'hA5A5_0F0F);
    reg_read(4'd4, d); check("R2 rem rw", d, 32'h1234_5678);
  endtask

  task automatic t_insert();
    logic [31:0] d;
    slot_event(2'b10, 5'd7);
    reg_read(4'd0, d); check("R3 ins one-hot", d, 32'h0000_0080);
    reg_read(4'd4, d); check("R3 rem wiped", d, 32'h0);
    check("R5 status after insert", {24'h0, evt_sts_o}, 32'h02);
  endtask

  task automatic t_remove();
    logic [31:0] d;
    slot_event(2'b11, 5'd31);
    reg_read(4'd4, d); check("R4 rem one-hot", d, 32'h8000_0000);
    reg_read(4'd0, d); check("R4 ins wiped", d, 32'h0);
  endtask

  task automatic t_sts_clear();
    @(negedge clk_i); sts_clr_i = 8'h02;
    @(negedge clk_i); sts_clr_i = '0;
    check("R5 status cleared", {24'h0, evt_sts_o}, 32'h0);
    // event and clear together: event wins
    @(negedge clk_i); sts_clr_i = 8'h02; slot_ev_i = 2'b10; slot_idx_i = 5'd1;
    @(negedge clk_i); sts_clr_i = '0; slot_ev_i = 2'b00;
    check("R5 set beats clear", {24'h0, evt_sts_o}, 32'h02);
    @(negedge clk_i); sts_clr_i = 8'h02;
    @(negedge clk_i); sts_clr_i = '0;
  endtask

  task automatic t_cold();
    logic [31:0] d;
    reg_write(4'd0, 32'h0000_F000);
    reg_write(4'd4, 32'h0000_000F);
    slot_event(2'b01, 5'd3);
    reg_read(4'd0, d); check("R6 ins unchanged", d, 32'h0000_F000);
    reg_read(4'd4, d); check("R6 rem unchanged", d, 32'h0000_000F);
    check("R6 status unchanged", {24'h0, evt_sts_o}, 32'h0);
  endtask

  task automatic t_eject();
    logic [31:0] d;
    reg_write(4'd8, 32'h0000_0C00);
    check("R7 pulse", {31'h0, ej_vld_o}, 32'h1);
    check("R7 slot", {27'h0, ej_slot_o}, 32'd10);
    @(negedge clk_i);
    check("R7 single cycle", {31'h0, ej_vld_o}, 32'h0);
    reg_write(4'd8, 32'h8000_0000);
    check("R7 pulse top slot", {31'h0, ej_vld_o}, 32'h1);
    check("R7 slot 31", {27'h0, ej_slot_o}, 32'd31);
    reg_read(4'd8, d); check("R9 eject reads zero", d, 32'h0);
  endtask

  task automatic t_eject_block();
    reg_write(4'd8, 32'h0000_0011);
    check("R8 non-capable slot 0", {31'h0, ej_vld_o}, 32'h0);
    reg_write(4'd8, 32'h0000_0030);
    check("R8 non-capable slot 4", {31'h0, ej_vld_o}, 32'h0);
    reg_write(4'd8, 32'h0);
    check("R8 zero write", {31'h0, ej_vld_o}, 32'h0);
  endtask

  task automatic t_rmv_ro();
    logic [31:0] d;
    reg_write(4'd12, 32'h0);
    reg_read(4'd12, d); check("R9 removable read-only", d, CAP);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    reg_write(4'd0, 32'h0000_00AA);
    reg_write(4'd4, 32'h0000_0055);
    reg_write(4'd2, 32'hFFFF_FFFF);
    reg_write(4'd6, 32'hFFFF_FFFF);
    reg_read(4'd0, d); check("R10 ins untouched", d, 32'h0000_00AA);
    reg_read(4'd4, d); check("R10 rem untouched", d, 32'h0000_0055);
    reg_read(4'd2, d); check("R10 offset 2 zero", d, 32'h0);
    reg_read(4'd15, d); check("R10 offset 15 zero", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 4'd0; reg_wdata_i = 32'hFFFF_FFFF;
    slot_ev_i = 2'b10; slot_idx_i = 5'd2;
    @(negedge clk_i);
    reg_wr_i = 1'b0; slot_ev_i = 2'b00;
    reg_read(4'd0, d); check("R11 event over write", d, 32'h0000_0004);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_sw_rw();
    t_insert();
    t_remove();
    t_sts_clear();
    t_cold();
    t_eject();
    t_eject_block();
    t_rmv_ro();
    t_unmapped();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule